// File: doc/BRIEF.md
# Soft-Start Reference Ramp Sequencer

This block drives the reference code of a digitally controlled regulator while the rail turns on and off. When a start command arrives, it freezes the reference at the feedback level measured at that moment, which is the pre-bias level. It waits a programmed number of update ticks. It then moves the reference toward the target by a fixed step on every tick. Ticks come from a divider that gives a 10 kHz update rate from the core clock. A stop command ramps the reference down to zero by a separate fall step. When the reference reaches zero, the sequencer shuts off the PWM and returns to idle. While idle, the reference follows the measured feedback code on every clock, so a later start never disturbs a charged output.

The PWM enable is gated. It rises only when the reference has reached the pre-bias level and the compensator's duty estimate exceeds a programmed minimum. The sequencer also watches the two saturation flags of the error ADC. While either flag is set on a tick, the normal ramp step is replaced by a saturation step that moves the reference in the direction that shrinks the error. The ramp then continues from wherever the reference ended up. The compensator arithmetic is outside this block.

Top module: `ssr_sequencer`

## Requirements
- R1: While `rst` is high, `vref` is 0, `pwm_en` is 0 and `done` is 0.
- R2: In idle, `vref` takes the value of `fb_code` on every clock edge, so it shows the previous cycle's feedback code. `pwm_en` stays 0 in idle.
- R3: An accepted `start_cmd` captures `fb_code` as both the reference and the pre-bias level. The reference then holds that value for `delay_ticks` ticks. Ticks fall every `TICK_DIV` clocks, counted from the start edge. The first ramp step lands on tick `delay_ticks`+1.
- R4: During the rise, each tick moves `vref` by `rise_step` toward `target` and clamps the result so it lands exactly on `target`. Between ticks, `vref` does not change.
- R5: `done` rises on the same edge at which `vref` becomes `target`. With no saturation, this is tick D+N, where D is `delay_ticks` and N = ceil(|target − pre-bias| / `rise_step`). `done` stays high until a stop is accepted.
- R6: `pwm_en` is set one clock after a cycle of the rise or hold phase in which `vref` ≥ pre-bias and `duty_est` > `min_duty`. Once set, it stays high until the sequencer returns to idle.
- R7: On a tick during the rise or fall, `sat_pos` (error ADC pinned at +31 LSB) lowers `vref` by `sat_step`, with a floor at 0. Otherwise `sat_neg` (pinned at −32 LSB) raises `vref` by `sat_step`, with a ceiling at full scale. In both cases the normal step is skipped and `done` cannot rise on that tick.
- R8: When saturation clears, the ramp resumes from the current `vref` with the normal step. This makes the ramp take longer.
- R9: A `stop_cmd` during the rise or hold phase starts the fall phase and clears `done`. In the fall phase, each tick lowers `vref` by `fall_step` with a floor at 0. Ticks restart at the stop edge.
- R10: On the tick at which `vref` reaches 0 in the fall phase, the sequencer returns to idle and `pwm_en` drops on that same edge.
- R11: A `stop_cmd` during the delay phase returns the sequencer to idle on the next edge, with no ramp step taken.
- R12: `start_cmd` is ignored outside idle, and `stop_cmd` is ignored in idle.
- R13: When `stop_cmd` and a tick fall on the same edge during the rise, the stop wins and no ramp step is applied on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| start_cmd | input | 1 | Turn-on request, one clock |
| stop_cmd | input | 1 | Turn-off request, one clock |
| delay_ticks | input | DLY_W | Turn-on delay in update ticks |
| rise_step | input | REF_W | Reference step per tick while rising |
| fall_step | input | REF_W | Reference step per tick while falling |
| target | input | REF_W | Commanded regulation reference |
| fb_code | input | REF_W | Measured feedback voltage code |
| sat_pos | input | 1 | Error ADC pinned at its positive limit |
| sat_neg | input | 1 | Error ADC pinned at its negative limit |
| sat_step | input | REF_W | Reference step per tick during saturation |
| duty_est | input | DUTY_W | Compensator's current pulse-width estimate |
| min_duty | input | DUTY_W | Minimum pulse width for enabling the PWM |
| vref | output | REF_W | Reference code to the error amplifier |
| pwm_en | output | 1 | PWM output enable |
| done | output | 1 | Reference has reached the target |

## Verification
A stop command and an update tick can land on the same edge during the rise. The bench provokes this by raising `stop_cmd` in the cycle just before a known tick edge. It judges the result by checking that `vref` still holds the value from the previous tick on that edge, and that the first fall step comes a full tick period later. A saturation flag and a ramp tick also meet on the same edge. The bench holds each flag across chosen ticks and checks that `vref` moves by the saturation step in the required direction, then resumes the normal step, with `done` delayed by the extra ticks.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    // Default widths and the update divider (200 MHz core clock to 10 kHz ticks)
    localparam int unsigned SSR_REF_W    = 12;
    localparam int unsigned SSR_DUTY_W   = 10;
    localparam int unsigned SSR_DLY_W    = 16;
    localparam int unsigned SSR_TICK_DIV = 20000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DELAY,
        ST_RISE,
        ST_HOLD,
        ST_FALL
    } seq_state_e;

    typedef enum logic [1:0] {
        SAT_NONE,
        SAT_LOWER,
        SAT_RAISE
    } sat_dir_e;

    typedef struct packed {
        logic start_ok;
        logic stop_ok;
        logic restart;
    } seq_cmd_t;

    // Positive saturation means the reference sits too far above the feedback
    function automatic sat_dir_e decode_sat(input logic pos, input logic neg);
        if (pos)      return SAT_LOWER;
        else if (neg) return SAT_RAISE;
        else          return SAT_NONE;
    endfunction

    function automatic logic ramp_phase(input seq_state_e st);
        return (st == ST_RISE) || (st == ST_FALL);
    endfunction

endpackage

// File: rtl/ssr_tick_gen.sv
module ssr_tick_gen #(
    parameter int unsigned DIV = 20000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign tick = run && (cnt_q == LAST);

endmodule

// File: rtl/ssr_step_calc.sv
module ssr_step_calc import ssr_pkg::*; #(
    parameter int unsigned W = 12
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] goal,
    input  logic [W-1:0] step,
    input  sat_dir_e     sat_dir,
    input  logic [W-1:0] sat_step,
    output logic [W-1:0] nxt,
    output logic         landed
);
    logic [W:0]   sum;
    logic [W-1:0] gap;

    always_comb begin
        sum = '0;
        gap = '0;
        nxt = cur;
        unique case (sat_dir)
            SAT_LOWER: begin
                nxt = (cur > sat_step) ? (cur - sat_step) : '0;
            end
            SAT_RAISE: begin
                sum = {1'b0, cur} + {1'b0, sat_step};
                nxt = sum[W] ? '1 : sum[W-1:0];
            end
            default: begin
                if (cur < goal) begin
                    gap = goal - cur;
                    nxt = (step >= gap) ? goal : (cur + step);
                end else if (cur > goal) begin
                    gap = cur - goal;
                    nxt = (step >= gap) ? goal : (cur - step);
                end else begin
                    nxt = goal;
                end
            end
        endcase
        landed = (sat_dir == SAT_NONE) && (nxt == goal);
    end

endmodule

// File: rtl/ssr_pwm_gate.sv
module ssr_pwm_gate #(
    parameter int unsigned REF_W  = 12,
    parameter int unsigned DUTY_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic              clear,
    input  logic [REF_W-1:0]  vref,
    input  logic [REF_W-1:0]  floor_lvl,
    input  logic [DUTY_W-1:0] duty,
    input  logic [DUTY_W-1:0] min_duty,
    output logic              en
);
    logic permit;

    assign permit = arm && (vref >= floor_lvl) && (duty > min_duty);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            en <= 1'b0;
        end else if (permit) begin
            en <= 1'b1;
        end
    end

endmodule

// File: rtl/ssr_sequencer.sv
module ssr_sequencer import ssr_pkg::*; #(
    parameter int unsigned REF_W    = SSR_REF_W,
    parameter int unsigned DUTY_W   = SSR_DUTY_W,
    parameter int unsigned DLY_W    = SSR_DLY_W,
    parameter int unsigned TICK_DIV = SSR_TICK_DIV
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_cmd,
    input  logic              stop_cmd,
    input  logic [DLY_W-1:0]  delay_ticks,
    input  logic [REF_W-1:0]  rise_step,
    input  logic [REF_W-1:0]  fall_step,
    input  logic [REF_W-1:0]  target,
    input  logic [REF_W-1:0]  fb_code,
    input  logic              sat_pos,
    input  logic              sat_neg,
    input  logic [REF_W-1:0]  sat_step,
    input  logic [DUTY_W-1:0] duty_est,
    input  logic [DUTY_W-1:0] min_duty,
    output logic [REF_W-1:0]  vref,
    output logic              pwm_en,
    output logic              done
);
    localparam logic [DLY_W-1:0] ONE_TICK = DLY_W'(1);

    seq_state_e       state_q, state_d;
    logic [DLY_W-1:0] dcnt_q, dcnt_d;
    logic [REF_W-1:0] vref_q, vref_d;
    logic [REF_W-1:0] prebias_q, prebias_d;

    seq_cmd_t         cmd;
    logic             tick;
    sat_dir_e         sat_dir;
    logic [REF_W-1:0] goal, step_sel, step_nxt;
    logic             step_landed;
    logic             gate_arm, gate_clear;

    // Command acceptance
    always_comb begin
        cmd.start_ok = (state_q == ST_IDLE) && start_cmd;
        cmd.stop_ok  = stop_cmd && ((state_q == ST_RISE) || (state_q == ST_HOLD));
        cmd.restart  = cmd.start_ok || cmd.stop_ok;
    end

    ssr_tick_gen #(
        .DIV(TICK_DIV)
    ) u_tick (
        .clk     (clk),
        .rst     (rst),
        .run     (state_q != ST_IDLE),
        .restart (cmd.restart),
        .tick    (tick)
    );

    // Step selection: rise toward target, fall toward zero
    assign sat_dir  = ramp_phase(state_q) ? decode_sat(sat_pos, sat_neg) : SAT_NONE;
    assign goal     = (state_q == ST_FALL) ? '0 : target;
    assign step_sel = (state_q == ST_FALL) ? fall_step : rise_step;

    ssr_step_calc #(
        .W(REF_W)
    ) u_step (
        .cur      (vref_q),
        .goal     (goal),
        .step     (step_sel),
        .sat_dir  (sat_dir),
        .sat_step (sat_step),
        .nxt      (step_nxt),
        .landed   (step_landed)
    );

    // Sequencing
    always_comb begin
        state_d   = state_q;
        dcnt_d    = dcnt_q;
        vref_d    = vref_q;
        prebias_d = prebias_q;
        unique case (state_q)
            ST_IDLE: begin
                vref_d = fb_code;
                if (cmd.start_ok) begin
                    prebias_d = fb_code;
                    dcnt_d    = delay_ticks;
                    state_d   = (delay_ticks == '0) ? ST_RISE : ST_DELAY;
                end
            end
            ST_DELAY: begin
                if (stop_cmd) begin
                    state_d = ST_IDLE;
                end else if (tick) begin
                    if (dcnt_q <= ONE_TICK) begin
                        state_d = ST_RISE;
                    end else begin
                        dcnt_d = dcnt_q - ONE_TICK;
                    end
                end
            end
            ST_RISE: begin
                if (cmd.stop_ok) begin
                    state_d = ST_FALL;
                end else if (tick) begin
                    vref_d = step_nxt;
                    if (step_landed) begin
                        state_d = ST_HOLD;
                    end
                end
            end
            ST_HOLD: begin
                if (cmd.stop_ok) begin
                    state_d = ST_FALL;
                end
            end
            ST_FALL: begin
                if (tick) begin
                    vref_d = step_nxt;
                    if (step_landed) begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            dcnt_q    <= '0;
            vref_q    <= '0;
            prebias_q <= '0;
        end else begin
            state_q   <= state_d;
            dcnt_q    <= dcnt_d;
            vref_q    <= vref_d;
            prebias_q <= prebias_d;
        end
    end

    // PWM enable gating
    assign gate_arm   = (state_q == ST_RISE) || (state_q == ST_HOLD);
    assign gate_clear = (state_d == ST_IDLE);

    ssr_pwm_gate #(
        .REF_W  (REF_W),
        .DUTY_W (DUTY_W)
    ) u_gate (
        .clk       (clk),
        .rst       (rst),
        .arm       (gate_arm),
        .clear     (gate_clear),
        .vref      (vref_q),
        .floor_lvl (prebias_q),
        .duty      (duty_est),
        .min_duty  (min_duty),
        .en        (pwm_en)
    );

    assign vref = vref_q;
    assign done = (state_q == ST_HOLD);

endmodule

// File: rtl/ssr_sequencer_chk.sv
module ssr_sequencer_chk import ssr_pkg::*; #(
    parameter int unsigned REF_W  = 12,
    parameter int unsigned DUTY_W = 10
) (
    input logic              clk,
    input logic              rst,
    input seq_state_e        state,
    input logic              tick,
    input logic              stop_cmd,
    input logic [REF_W-1:0]  vref,
    input logic [REF_W-1:0]  fb_code,
    input logic [REF_W-1:0]  target,
    input logic [REF_W-1:0]  prebias,
    input logic [DUTY_W-1:0] duty_est,
    input logic [DUTY_W-1:0] min_duty,
    input logic              pwm_en,
    input logic              done
);

    assert_idle_tracks_fb_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |=> (vref == $past(fb_code)));

    assert_hold_between_ticks_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RISE && !tick) |=> $stable(vref));

    assert_done_at_target_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (vref == target));

    assert_pwm_gate_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_en) |-> ($past(duty_est > min_duty) && $past(vref >= prebias)));

    assert_idle_pwm_off_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !pwm_en);

    assert_delay_abort_R11: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DELAY && stop_cmd) |=> (state == ST_IDLE));

    assert_stop_beats_tick_R13: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RISE && stop_cmd && tick) |=> (state == ST_FALL && $stable(vref)));

endmodule

bind ssr_sequencer ssr_sequencer_chk #(
    .REF_W  (REF_W),
    .DUTY_W (DUTY_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .state    (state_q),
    .tick     (tick),
    .stop_cmd (stop_cmd),
    .vref     (vref_q),
    .fb_code  (fb_code),
    .target   (target),
    .prebias  (prebias_q),
    .duty_est (duty_est),
    .min_duty (min_duty),
    .pwm_en   (pwm_en),
    .done     (done)
);

// File: tb/ssr_sequencer_test.sv
module ssr_sequencer_test;
    localparam int TD = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_cmd = 1'b0, stop_cmd = 1'b0;
    logic [15:0] delay_ticks = '0;
    logic [11:0] rise_step = 12'd100, fall_step = 12'd200, target = 12'd1000;
    logic [11:0] fb_code = '0, sat_step = 12'd50;
    logic        sat_pos = 1'b0, sat_neg = 1'b0;
    logic [9:0]  duty_est = 10'd50, min_duty = 10'd20;
    logic [11:0] vref;
    logic        pwm_en, done;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;

    typedef struct {
        int    cyc;
        int    v;
        bit    p;
        bit    d;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ssr_sequencer #(
        .REF_W(12), .DUTY_W(10), .DLY_W(16), .TICK_DIV(TD)
    ) uut (
        .clk(clk), .rst(rst), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
        .delay_ticks(delay_ticks), .rise_step(rise_step), .fall_step(fall_step),
        .target(target), .fb_code(fb_code), .sat_pos(sat_pos), .sat_neg(sat_neg),
        .sat_step(sat_step), .duty_est(duty_est), .min_duty(min_duty),
        .vref(vref), .pwm_en(pwm_en), .done(done)
    );

    task automatic push_exp(input int c, input int v, input bit p, input bit d, input string t);
        exp_t item;
        int   i = 0;
        item.cyc = c; item.v = v; item.p = p; item.d = d; item.tag = t;
        while (i < sb.size() && sb[i].cyc <= c) i++;
        sb.insert(i, item);
    endtask

    task automatic compare(input string t, input int v, input bit p, input bit d);
        n_checks++;
        if (vref !== v[11:0] || pwm_en !== p || done !== d) begin
            n_fail++;
            $display("FAIL %s cyc=%0d actual vref=%0d pwm=%0b done=%0b expected vref=%0d pwm=%0b done=%0b",
                     t, cyc, vref, pwm_en, done, v, p, d);
        end
    endtask

    // Monitor: pops expectations as their cycle comes up
    always @(negedge clk) begin
        if (!rst) begin
            while (sb.size() > 0 && sb[0].cyc <= cyc) begin
                exp_t item;
                item = sb.pop_front();
                if (item.cyc < cyc) begin
                    n_checks++;
                    n_fail++;
                    $display("FAIL %s missed expectation at cyc=%0d actual cyc=%0d expected cyc=%0d",
                             item.tag, item.cyc, cyc, item.cyc);
                end else begin
                    compare(item.tag, item.v, item.p, item.d);
                end
            end
        end
    end

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual cyc=%0d expected completion", cyc);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int e0, f0, g0, s;
        repeat (4) @(negedge clk);
        compare("R1 reset state", 0, 0, 0);
        fb_code = 12'd77;
        @(negedge clk);
        compare("R1 reset holds vref", 0, 0, 0);
        rst = 1'b0;

        // R2: idle tracking
        @(negedge clk);
        fb_code = 12'd123; push_exp(cyc + 1, 123, 0, 0, "R2");
        @(negedge clk);
        fb_code = 12'd321; push_exp(cyc + 1, 321, 0, 0, "R2");
        @(negedge clk);
        fb_code = 12'd300;
        @(negedge clk);

        // Main ramp from pre-bias 300, delay 2 ticks
        delay_ticks = 16'd2;
        start_cmd = 1'b1; e0 = cyc + 1;
        push_exp(e0, 300, 0, 0, "R3");
        push_exp(e0 + TD, 300, 0, 0, "R3");
        push_exp(e0 + 2*TD, 300, 0, 0, "R3");
        push_exp(e0 + 2*TD + 1, 300, 1, 0, "R6");
        for (int k = 3; k <= 9; k++)
            push_exp(e0 + k*TD, 300 + 100*(k-2), 1, (k == 9), (k == 9) ? "R5" : "R4");
        push_exp(e0 + 3*TD + 4, 400, 1, 0, "R4");
        push_exp(e0 + 8*TD + 3, 900, 1, 0, "R5");
        @(negedge clk);
        start_cmd = 1'b0; fb_code = 12'd700;
        wait_until(e0 + 9*TD + 2);

        // R12: start ignored in hold
        start_cmd = 1'b1; s = cyc;
        push_exp(s + 2*TD, 1000, 1, 1, "R12");
        @(negedge clk);
        start_cmd = 1'b0;
        wait_until(s + 2*TD + 1);

        // Stop from hold: fall by 200 per tick
        stop_cmd = 1'b1; f0 = cyc + 1;
        push_exp(f0, 1000, 1, 0, "R9");
        for (int k = 1; k <= 5; k++)
            push_exp(f0 + k*TD, 1000 - 200*k, (k < 5), 0, (k == 5) ? "R10" : "R9");
        push_exp(f0 + 5*TD + 1, 700, 0, 0, "R2");
        @(negedge clk);
        stop_cmd = 1'b0;
        wait_until(f0 + 5*TD + 3);

        // R12: stop ignored in idle
        stop_cmd = 1'b1; fb_code = 12'd710; s = cyc;
        push_exp(s + 1, 710, 0, 0, "R12");
        push_exp(s + 3, 710, 0, 0, "R12");
        @(negedge clk);
        stop_cmd = 1'b0;
        wait_until(s + 4);

        // R11: stop during delay
        fb_code = 12'd700;
        @(negedge clk);
        delay_ticks = 16'd5;
        start_cmd = 1'b1; e0 = cyc + 1;
        push_exp(e0 + TD + 2, 700, 0, 0, "R3");
        @(negedge clk);
        start_cmd = 1'b0; fb_code = 12'd444;
        wait_until(e0 + TD + 3);
        stop_cmd = 1'b1; g0 = cyc + 1;
        push_exp(g0, 700, 0, 0, "R11");
        push_exp(g0 + 1, 444, 0, 0, "R11");
        push_exp(e0 + 7*TD, 444, 0, 0, "R11");
        @(negedge clk);
        stop_cmd = 1'b0;
        wait_until(e0 + 7*TD + 1);

        // Saturation override and pre-bias gate
        fb_code = 12'd500; duty_est = 10'd10; delay_ticks = 16'd0;
        @(negedge clk);
        start_cmd = 1'b1; e0 = cyc + 1;
        push_exp(e0 + TD, 600, 0, 0, "R4");
        push_exp(e0 + 2*TD, 550, 0, 0, "R7");
        push_exp(e0 + 3*TD, 500, 0, 0, "R7");
        push_exp(e0 + 3*TD + 3, 500, 0, 0, "R7");
        push_exp(e0 + 4*TD, 450, 0, 0, "R7");
        push_exp(e0 + 4*TD + 3, 450, 0, 0, "R6");
        push_exp(e0 + 5*TD, 550, 0, 0, "R8");
        push_exp(e0 + 5*TD + 1, 550, 1, 0, "R6");
        push_exp(e0 + 6*TD, 650, 1, 0, "R8");
        push_exp(e0 + 7*TD, 700, 1, 0, "R7");
        push_exp(e0 + 8*TD, 800, 1, 0, "R8");
        push_exp(e0 + 9*TD, 900, 1, 0, "R8");
        push_exp(e0 + 10*TD, 1000, 1, 1, "R8");
        @(negedge clk);
        start_cmd = 1'b0;
        wait_until(e0 + TD);
        sat_pos = 1'b1;
        wait_until(e0 + 4*TD);
        sat_pos = 1'b0; duty_est = 10'd50;
        wait_until(e0 + 6*TD);
        sat_neg = 1'b1;
        wait_until(e0 + 7*TD);
        sat_neg = 1'b0;
        wait_until(e0 + 10*TD + 1);
        stop_cmd = 1'b1; f0 = cyc + 1;
        push_exp(f0 + 5*TD, 0, 0, 0, "R10");
        @(negedge clk);
        stop_cmd = 1'b0; fb_code = 12'd0;
        wait_until(f0 + 5*TD + 2);

        // R13: stop on the same edge as a ramp tick
        @(negedge clk);
        start_cmd = 1'b1; e0 = cyc + 1;
        push_exp(e0 + 1, 0, 1, 0, "R6");
        push_exp(e0 + TD, 100, 1, 0, "R4");
        push_exp(e0 + 2*TD, 100, 1, 0, "R13");
        push_exp(e0 + 3*TD - 1, 100, 1, 0, "R13");
        push_exp(e0 + 3*TD, 0, 0, 0, "R13");
        push_exp(e0 + 3*TD + 2, 0, 0, 0, "R2");
        @(negedge clk);
        start_cmd = 1'b0;
        wait_until(e0 + 2*TD - 1);
        stop_cmd = 1'b1;
        @(negedge clk);
        stop_cmd = 1'b0;
        wait_until(e0 + 3*TD + 4);

        if (sb.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL scoreboard actual pending=%0d expected pending=0", sb.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule